// File: doc/BRIEF.md
# Vertical Link Lane Repair Steering

This block sits between a memory controller's line datapath and a 256-lane vertical data link through a die stack. A 512-bit line crosses the link in two beats. Lane i carries line bit i in the first beat and line bit 256+i in the second. Lanes 0, 64, 128 and 192 are held in reserve as stand-by lanes. On every write, the eight line bits that those four lanes carry in the two beats are also copied into an 8-bit swap field, which the controller keeps in the line's metadata. A stand-by lane is therefore free to carry another lane's traffic.

When a lane has been diagnosed as broken, its configuration entry marks it faulty and names one stand-by lane. On the write side, the block then drives the faulty lane's bits onto that stand-by lane in both beats. On the read side, it takes the repaired lane's bits back from the stand-by lane and restores the stand-by lane's own bits from the swap field. The configuration is a long shift register loaded one bit per cycle over two redundant serial inputs. It only takes effect on an explicit load strobe, so the mapping never changes in the middle of a line. A load that would give one stand-by lane two faulty lanes is refused and flagged.

Top module: `lane_repair_redirector`

## Requirements
- R1: With no lane marked faulty, tx_lanes equals wr_line and rd_line equals rx_lanes. Lane i is at bit i for beat 0 and at bit 256+i for beat 1.
- R2: wr_swap[b*4+k] always equals wr_line[b*256 + k*64] for beat b and stand-by index k. This gives line bits 0, 64, 128, 192, 256, 320, 384 and 448 in swap bits 0 to 7.
- R3: When lane f is faulty and assigned stand-by index k, tx_lanes[b*256 + k*64] carries wr_line[b*256+f] in both beats. Every other non-stand-by lane carries its own bit.
- R4: On read, a faulty lane f assigned to index k returns rx_lanes[b*256 + k*64] as rd_line[b*256+f] in both beats.
- R5: On read, a stand-by lane that is in use returns its own bits from the swap field: rd_line[b*256+k*64] = rx_swap[b*4+k]. An unused stand-by lane returns its received bit.
- R6: A configuration bit is shifted in on each cycle in which cfg_vld_a or cfg_vld_b is high. The A input wins when both are valid. The last bit shifted in is position 0. The entry of lane i holds positions 3i (select bit 0), 3i+1 (select bit 1) and 3i+2 (fault flag).
- R7: The mapping changes only in the cycle after a high cfg_load, using the shift register as it was before that edge. Shifting without a load has no effect on tx_lanes or rd_line.
- R8: If cfg_load finds two or more faulty lanes that name the same stand-by index, cfg_err is set and the previous mapping is kept. An accepted load clears cfg_err.
- R9: The fault flags in the entries of lanes 0, 64, 128 and 192 are ignored. They count toward no conflict and repair nothing.
- R10: After reset, no lane is faulty and cfg_err is 0.
- R11: A faulty lane's corruption in both beats is fully undone: feeding tx_lanes back with that lane's bits inverted, together with wr_swap, gives rd_line equal to wr_line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bit_a | input | 1 | Serial configuration bit, channel A |
| cfg_vld_a | input | 1 | Channel A bit valid |
| cfg_bit_b | input | 1 | Serial configuration bit, channel B |
| cfg_vld_b | input | 1 | Channel B bit valid |
| cfg_load | input | 1 | Apply the shifted configuration |
| cfg_err | output | 1 | Last load refused for stand-by conflict |
| wr_line | input | 512 | Line to write, beat b in bits b*256 upward |
| tx_lanes | output | 512 | Lane values driven onto the link, per beat |
| wr_swap | output | 8 | Swap field to store in metadata |
| rx_lanes | input | 512 | Lane values received from the link, per beat |
| rx_swap | input | 8 | Swap field read back from metadata |
| rd_line | output | 512 | Restored line |

## Verification
The bench aims at the corners where a lane index meets a beat. It checks that the second beat is steered as well as the first. A design that repaired only beat 0 would fail the round trip with a lane broken in both beats. It reads back a used stand-by lane whose own bit differs from the bit it carried, so a design that forgot the swap field would return the repaired lane's data there. It loads the configuration while both serial channels disagree, which catches a wrong priority between the channels. It then issues a conflicting load, where a design that applied the mapping anyway would steer the wrong lane, and a load that marks a stand-by lane faulty, which a design that counted it would refuse.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
  localparam int unsigned DEF_LANES  = 256;
  localparam int unsigned DEF_SPARES = 4;
  localparam int unsigned DEF_BEATS  = 2;

  // stand-by lanes sit at multiples of the spacing lanes/spares
  function automatic logic is_standby(int unsigned lane, int unsigned lanes,
                                      int unsigned spares);
    return (lane % (lanes / spares)) == 0;
  endfunction
endpackage

// File: rtl/lrr_cfg_loader.sv
module lrr_cfg_loader
  import lrr_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SPARES = DEF_SPARES
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bit_a,
  input  logic                               vld_a,
  input  logic                               bit_b,
  input  logic                               vld_b,
  input  logic                               load,
  output logic [LANES-1:0]                   map_fault,
  output logic [LANES-1:0][$clog2(SPARES)-1:0] map_sel,
  output logic                               conflict,
  output logic                               err
);
  localparam int unsigned SEL_W   = $clog2(SPARES);
  localparam int unsigned ENTRY_W = SEL_W + 1;
  localparam int unsigned SH_W    = LANES * ENTRY_W;

  logic [SH_W-1:0]              shreg_q, shreg_d;
  logic                         shift_en, in_bit;
  logic [LANES-1:0]             cand_fault;
  logic [LANES-1:0][SEL_W-1:0]  cand_sel;
  logic [SPARES-1:0][LANES-1:0] claim;
  logic [SPARES-1:0]            over;
  logic [LANES-1:0]             fault_d;
  logic [LANES-1:0][SEL_W-1:0]  sel_d;
  logic                         err_d, apply_en;

  assign shift_en = vld_a | vld_b;
  assign in_bit   = vld_a ? bit_a : bit_b;

  always_comb begin
    shreg_d = shreg_q;
    if (shift_en) shreg_d = {shreg_q[SH_W-2:0], in_bit};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign cand_sel[i] = shreg_q[i*ENTRY_W +: SEL_W];
    if (is_standby(i, LANES, SPARES)) begin : g_sb
      assign cand_fault[i] = 1'b0;
    end else begin : g_rl
      assign cand_fault[i] = shreg_q[i*ENTRY_W + SEL_W];
    end
  end

  for (genvar k = 0; k < SPARES; k++) begin : g_cnt
    for (genvar i = 0; i < LANES; i++) begin : g_ln
      assign claim[k][i] = cand_fault[i] && (cand_sel[i] == SEL_W'(k));
    end
    assign over[k] = ($countones(claim[k]) > 1);
  end

  assign conflict = |over;
  assign apply_en = load && !conflict;

  always_comb begin
    fault_d = map_fault;
    sel_d   = map_sel;
    err_d   = err;
    if (load) err_d = conflict;
    if (apply_en) begin
      fault_d = cand_fault;
      sel_d   = cand_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      map_fault <= '0;
      map_sel   <= '0;
      err       <= 1'b0;
    end else begin
      if (shift_en) shreg_q <= shreg_d;
      if (apply_en) begin
        map_fault <= fault_d;
        map_sel   <= sel_d;
      end
      if (load) err <= err_d;
    end
  end
endmodule

// File: rtl/lrr_tx_steer.sv
module lrr_tx_steer
  import lrr_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SPARES = DEF_SPARES,
  parameter int unsigned BEATS  = DEF_BEATS
) (
  input  logic [SPARES-1:0][LANES-1:0] owner,
  input  logic [SPARES-1:0]            spare_used,
  input  logic [LANES*BEATS-1:0]       wr_line,
  output logic [LANES*BEATS-1:0]       tx_lanes,
  output logic [SPARES*BEATS-1:0]      wr_swap
);
  localparam int unsigned STRIDE = LANES / SPARES;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (is_standby(i, LANES, SPARES)) begin : g_sb
        localparam int unsigned K = i / STRIDE;
        assign tx_lanes[b*LANES+i] = spare_used[K]
            ? |(owner[K] & wr_line[b*LANES +: LANES])
            : wr_line[b*LANES+i];
        assign wr_swap[b*SPARES+K] = wr_line[b*LANES+i];
      end else begin : g_rl
        assign tx_lanes[b*LANES+i] = wr_line[b*LANES+i];
      end
    end
  end
endmodule

// File: rtl/lrr_rx_steer.sv
module lrr_rx_steer
  import lrr_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SPARES = DEF_SPARES,
  parameter int unsigned BEATS  = DEF_BEATS
) (
  input  logic [LANES-1:0]                     map_fault,
  input  logic [LANES-1:0][$clog2(SPARES)-1:0] map_sel,
  input  logic [SPARES-1:0]                    spare_used,
  input  logic [LANES*BEATS-1:0]               rx_lanes,
  input  logic [SPARES*BEATS-1:0]              rx_swap,
  output logic [LANES*BEATS-1:0]               rd_line
);
  localparam int unsigned STRIDE = LANES / SPARES;

  logic [BEATS-1:0][SPARES-1:0] spare_rx;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar k = 0; k < SPARES; k++) begin : g_sp
      assign spare_rx[b][k] = rx_lanes[b*LANES + k*STRIDE];
    end
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (is_standby(i, LANES, SPARES)) begin : g_sb
        localparam int unsigned K = i / STRIDE;
        assign rd_line[b*LANES+i] = spare_used[K] ? rx_swap[b*SPARES+K]
                                                  : rx_lanes[b*LANES+i];
      end else begin : g_rl
        assign rd_line[b*LANES+i] = map_fault[i] ? spare_rx[b][map_sel[i]]
                                                 : rx_lanes[b*LANES+i];
      end
    end
  end
endmodule

// File: rtl/lane_repair_redirector.sv
module lane_repair_redirector
  import lrr_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SPARES = DEF_SPARES,
  parameter int unsigned BEATS  = DEF_BEATS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_bit_a,
  input  logic                      cfg_vld_a,
  input  logic                      cfg_bit_b,
  input  logic                      cfg_vld_b,
  input  logic                      cfg_load,
  output logic                      cfg_err,
  input  logic [LANES*BEATS-1:0]    wr_line,
  output logic [LANES*BEATS-1:0]    tx_lanes,
  output logic [SPARES*BEATS-1:0]   wr_swap,
  input  logic [LANES*BEATS-1:0]    rx_lanes,
  input  logic [SPARES*BEATS-1:0]   rx_swap,
  output logic [LANES*BEATS-1:0]    rd_line
);
  localparam int unsigned SEL_W = $clog2(SPARES);

  logic                         rst_meta_n, rst_sync_n;
  logic [LANES-1:0]             map_fault;
  logic [LANES-1:0][SEL_W-1:0]  map_sel;
  logic                         conflict;
  logic [SPARES-1:0][LANES-1:0] owner;
  logic [SPARES-1:0]            spare_used;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  lrr_cfg_loader #(.LANES(LANES), .SPARES(SPARES)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_a    (cfg_bit_a),
    .vld_a    (cfg_vld_a),
    .bit_b    (cfg_bit_b),
    .vld_b    (cfg_vld_b),
    .load     (cfg_load),
    .map_fault(map_fault),
    .map_sel  (map_sel),
    .conflict (conflict),
    .err      (cfg_err)
  );

  for (genvar k = 0; k < SPARES; k++) begin : g_own
    for (genvar i = 0; i < LANES; i++) begin : g_ln
      assign owner[k][i] = map_fault[i] && (map_sel[i] == SEL_W'(k));
    end
    assign spare_used[k] = |owner[k];
  end

  lrr_tx_steer #(.LANES(LANES), .SPARES(SPARES), .BEATS(BEATS)) u_tx (
    .owner     (owner),
    .spare_used(spare_used),
    .wr_line   (wr_line),
    .tx_lanes  (tx_lanes),
    .wr_swap   (wr_swap)
  );

  lrr_rx_steer #(.LANES(LANES), .SPARES(SPARES), .BEATS(BEATS)) u_rx (
    .map_fault (map_fault),
    .map_sel   (map_sel),
    .spare_used(spare_used),
    .rx_lanes  (rx_lanes),
    .rx_swap   (rx_swap),
    .rd_line   (rd_line)
  );
endmodule

// File: rtl/lrr_checker.sv
module lrr_checker
  import lrr_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SPARES = DEF_SPARES,
  parameter int unsigned BEATS  = DEF_BEATS
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 cfg_load,
  input logic                                 conflict,
  input logic                                 cfg_err,
  input logic [LANES-1:0]                     map_fault,
  input logic [LANES-1:0][$clog2(SPARES)-1:0] map_sel,
  input logic [SPARES-1:0][LANES-1:0]         owner,
  input logic [LANES*BEATS-1:0]               wr_line,
  input logic [LANES*BEATS-1:0]               tx_lanes
);
  localparam int unsigned STRIDE = LANES / SPARES;

  logic [LANES-1:0] sb_mask;
  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign sb_mask[i] = is_standby(i, LANES, SPARES);
  end

  AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && conflict |=> cfg_err); // R8
  AST_MAP_KEPT_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && conflict |=> $stable(map_fault) && $stable(map_sel)); // R8
  AST_MAP_HOLDS_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(map_fault) && $stable(map_sel)); // R7
  AST_STANDBY_NOT_REPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (map_fault & sb_mask) == '0); // R9

  for (genvar k = 0; k < SPARES; k++) begin : g_sp
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owner[k]) <= 1); // R8
    for (genvar b = 0; b < BEATS; b++) begin : g_bt
      AST_IDLE_SPARE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        owner[k] == '0 |-> tx_lanes[b*LANES+k*STRIDE] == wr_line[b*LANES+k*STRIDE]); // R1
    end
  end
endmodule

bind lane_repair_redirector lrr_checker #(
  .LANES(LANES), .SPARES(SPARES), .BEATS(BEATS)
) u_lrr_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cfg_load (cfg_load),
  .conflict (conflict),
  .cfg_err  (cfg_err),
  .map_fault(map_fault),
  .map_sel  (map_sel),
  .owner    (owner),
  .wr_line  (wr_line),
  .tx_lanes (tx_lanes)
);

// File: tb/test_lane_repair_redirector.sv
module test_lane_repair_redirector;
  localparam int L = 256, S = 4, W = 512, STR = 64, EW = 3, CW = L*EW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_bit_a = 0, cfg_vld_a = 0, cfg_bit_b = 0, cfg_vld_b = 0, cfg_load = 0;
  logic [W-1:0] wr_line = '0, rx_lanes = '0;
  logic [7:0]   rx_swap = '0;
  logic         cfg_err;
  logic [W-1:0] tx_lanes, rd_line;
  logic [7:0]   wr_swap;

  lane_repair_redirector i_lane_repair_redirector (
    .clk(clk), .rst_n(rst_n),
    .cfg_bit_a(cfg_bit_a), .cfg_vld_a(cfg_vld_a),
    .cfg_bit_b(cfg_bit_b), .cfg_vld_b(cfg_vld_b),
    .cfg_load(cfg_load), .cfg_err(cfg_err),
    .wr_line(wr_line), .tx_lanes(tx_lanes), .wr_swap(wr_swap),
    .rx_lanes(rx_lanes), .rx_swap(rx_swap), .rd_line(rd_line)
  );

  int n_chk = 0, n_fail = 0;

  // behavioural reference state
  bit m_fault[L];
  int m_sel[L];
  bit m_err;
  bit shq[$];

  task automatic chk_v(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_s(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit shbit(int p);
    if (p < shq.size()) return shq[shq.size()-1-p];
    return 1'b0;
  endfunction

  function automatic logic [W-1:0] exp_tx();
    logic [W-1:0] e = wr_line;
    for (int i = 0; i < L; i++)
      if (m_fault[i])
        for (int b = 0; b < 2; b++) e[b*L + m_sel[i]*STR] = wr_line[b*L + i];
    return e;
  endfunction

  function automatic logic [7:0] exp_swap();
    logic [7:0] e;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < S; k++) e[b*S+k] = wr_line[b*L + k*STR];
    return e;
  endfunction

  function automatic logic [W-1:0] exp_rd();
    logic [W-1:0] e = rx_lanes;
    for (int i = 0; i < L; i++)
      if (m_fault[i])
        for (int b = 0; b < 2; b++) begin
          e[b*L + i]           = rx_lanes[b*L + m_sel[i]*STR];
          e[b*L + m_sel[i]*STR] = rx_swap[b*S + m_sel[i]];
        end
    return e;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      foreach (m_fault[i]) begin m_fault[i] = 0; m_sel[i] = 0; end
      m_err = 0;
      shq.delete();
    end else begin
      if (cfg_load) begin
        int cnt[S];
        bit cf[L];
        int cs[L];
        bit bad = 0;
        foreach (cnt[k]) cnt[k] = 0;
        for (int i = 0; i < L; i++) begin
          cf[i] = shbit(i*EW+2) && (i % STR != 0);
          cs[i] = shbit(i*EW) + 2*shbit(i*EW+1);
          if (cf[i]) cnt[cs[i]]++;
        end
        foreach (cnt[k]) if (cnt[k] > 1) bad = 1;
        m_err = bad;
        if (!bad) for (int i = 0; i < L; i++) begin m_fault[i] = cf[i]; m_sel[i] = cs[i]; end
      end
      if (cfg_vld_a || cfg_vld_b) begin
        shq.push_back(cfg_vld_a ? cfg_bit_a : cfg_bit_b);
        if (shq.size() > CW) void'(shq.pop_front());
      end
    end
  endtask

  task automatic compare_all();
    chk_v("R3 tx_lanes", tx_lanes, exp_tx());
    chk_s("R2 wr_swap", wr_swap, exp_swap());
    chk_v("R4 rd_line", rd_line, exp_rd());
    chk_s("R8 cfg_err", {7'd0, cfg_err}, {7'd0, m_err});
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #2;
    compare_all();
  endtask

  // mode 0: A only, 1: B only, 2: both valid with B inverted, 3: A with gaps
  task automatic send_cfg(logic [CW-1:0] v, int mode);
    for (int p = CW-1; p >= 0; p--) begin
      cfg_bit_a = v[p];
      cfg_bit_b = (mode == 2) ? ~v[p] : v[p];
      cfg_vld_a = (mode != 1);
      cfg_vld_b = (mode == 1 || mode == 2);
      step();
      if (mode == 3 && p % 8 == 0) begin
        cfg_vld_a = 0; cfg_vld_b = 0;
        step();
      end
    end
    cfg_vld_a = 0; cfg_vld_b = 0;
  endtask

  task automatic load_pulse();
    cfg_load = 1; step();
    cfg_load = 0; step();
  endtask

  function automatic logic [CW-1:0] put(logic [CW-1:0] v, int lane, int sel);
    v[lane*EW+2] = 1'b1;
    v[lane*EW +: 2] = 2'(sel);
    return v;
  endfunction

  function automatic logic [W-1:0] rnd();
    return {16{$urandom}} ^ {$urandom, $urandom, $urandom, $urandom,
                             $urandom, $urandom, $urandom, $urandom,
                             $urandom, $urandom, $urandom, $urandom,
                             $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [CW-1:0] c;
    logic [W-1:0]  pre;
    foreach (m_fault[i]) begin m_fault[i] = 0; m_sel[i] = 0; end
    m_err = 0;
    wr_line = rnd();
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();

    // R10: reset state is pass-through, no error
    chk_v("R10 tx after reset", tx_lanes, wr_line);
    chk_s("R10 cfg_err after reset", {7'd0, cfg_err}, 8'd0);

    // R1: pass-through under several patterns
    wr_line = '1; rx_lanes = {16{32'hA5A5_5A5A}}; rx_swap = 8'h3C; #1;
    chk_v("R1 tx all ones", tx_lanes, wr_line);
    chk_v("R1 rd passes", rd_line, rx_lanes);
    wr_line = {256{2'b10}}; #1;
    chk_v("R1 tx alternating", tx_lanes, wr_line);
    chk_s("R2 swap alternating", wr_swap, exp_swap());
    wr_line = rnd(); rx_lanes = rnd(); #1;
    chk_v("R1 rd random", rd_line, rx_lanes);
    step();

    // R6/R7: lane 5 -> index 1, lane 200 -> index 3, both channels, B inverted
    c = '0; c = put(c, 5, 1); c = put(c, 200, 3);
    wr_line = rnd(); wr_line[5] = ~wr_line[64]; wr_line[256+5] = ~wr_line[256+64];
    pre = wr_line;
    send_cfg(c, 2);
    chk_v("R7 no change before load", tx_lanes, pre);
    load_pulse();
    chk_s("R6 A preferred beat0 lane5->64", {7'd0, tx_lanes[64]}, {7'd0, wr_line[5]});
    chk_s("R3 beat1 lane5->64", {7'd0, tx_lanes[256+64]}, {7'd0, wr_line[256+5]});
    chk_s("R3 beat1 lane200->192", {7'd0, tx_lanes[256+192]}, {7'd0, wr_line[256+200]});
    chk_s("R2 swap under repair", wr_swap, exp_swap());

    // R11/R5: round trip with lane 5 broken in both beats
    rx_lanes = tx_lanes; rx_lanes[5] = ~rx_lanes[5]; rx_lanes[256+5] = ~rx_lanes[256+5];
    rx_swap = wr_swap; #1;
    chk_v("R11 round trip", rd_line, wr_line);
    chk_s("R5 stand-by 64 from swap", {7'd0, rd_line[64]}, {7'd0, wr_line[64]});
    chk_s("R5 unused stand-by 0 passes", {7'd0, rd_line[0]}, {7'd0, rx_lanes[0]});
    chk_s("R4 lane200 beat0", {7'd0, rd_line[200]}, {7'd0, rx_lanes[192]});
    step();

    // R8: conflict on index 2, mapping kept
    c = '0; c = put(c, 10, 2); c = put(c, 20, 2);
    send_cfg(c, 1);
    load_pulse();
    chk_s("R8 conflict flagged", {7'd0, cfg_err}, 8'd1);
    wr_line = rnd(); #1;
    chk_s("R8 old map kept", {7'd0, tx_lanes[64]}, {7'd0, wr_line[5]});
    chk_s("R8 no new repair", {7'd0, tx_lanes[128]}, {7'd0, wr_line[128]});

    // R9: stand-by lane 64 flagged faulty is ignored; lane 7 -> index 1
    c = '0; c = put(c, 64, 1); c = put(c, 7, 1); c = put(c, 128, 2);
    send_cfg(c, 3);
    load_pulse();
    chk_s("R9 no conflict, R8 err cleared", {7'd0, cfg_err}, 8'd0);
    wr_line = rnd(); #1;
    chk_s("R9 lane7 repaired", {7'd0, tx_lanes[256+64]}, {7'd0, wr_line[256+7]});
    chk_s("R9 spare 128 unused", {7'd0, tx_lanes[128]}, {7'd0, wr_line[128]});
    rx_lanes = rnd(); rx_swap = 8'h5A; #1;
    chk_s("R9 lane 64 read", {7'd0, rd_line[64]}, {7'd0, rx_swap[1]});
    step();

    // return to pass-through
    send_cfg('0, 0);
    load_pulse();
    wr_line = rnd(); rx_lanes = rnd(); #1;
    chk_v("R1 cleared map tx", tx_lanes, wr_line);
    chk_v("R1 cleared map rd", rd_line, rx_lanes);
    repeat (4) step();

    summary();
    $finish;
  end
endmodule